// File: doc/BRIEF.md
# Renamed Reorder Buffer with Operand Wakeup

This block is a small reorder buffer for a machine that issues in order and executes out of order. It holds add and subtract operations whose operands are renamed physical registers. Each slot keeps the operation, its source and destination register tags, the operand values with a known flag per operand, and the result once it exists. Slots form a circular queue. The issue side writes at the tail in program order, and the commit side retires from the head in the same order.

An execution engine, enabled by `execEnable`, picks one ready slot per cycle. A slot is ready when both operands are known and it has not yet run. The oldest ready slot, counted from the head, wins. The engine computes the result and broadcasts it with the destination tag. Every waiting operand in the buffer whose tag matches captures the value at the same clock edge. This includes an operand of an operation being written at the tail in that cycle. The head slot is offered for retirement as soon as it has executed, and it is freed when `commitReady` accepts it.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `issueReady` is 1, `commitValid` is 0 and `execFire` is 0.
- R2: An operation is accepted at a clock edge where `issueValid` and `issueReady` are both 1. `issueReady` is 0 exactly while all DEPTH slots are occupied. An operation offered while `issueReady` is 0 is dropped: it never executes and is never offered for commit.
- R3: `issueOp` 0 is ADD, with result A + B. `issueOp` 1 is SUB, with result A - B. Both are 32-bit two's complement and wrap modulo 2^32.
- R4: A slot whose operands are both known becomes eligible in the cycle after it is written. In a cycle with `execEnable` at 1 and an eligible slot, `execFire` is 1, and `execTag`/`execValue` show the chosen slot's destination tag and result in that same cycle. While `execEnable` is 0, `execFire` stays 0 and nothing executes.
- R5: When several slots are eligible, the one nearest the head in program order executes first. At most one slot executes per cycle, including when the queue has wrapped past the last slot.
- R6: A broadcast sets the value and known flag of every waiting operand in the buffer whose tag equals `execTag`. The woken slot becomes eligible in the next cycle.
- R7: An operation written in the same cycle as a broadcast captures the broadcast value for any source that is marked unknown and whose tag matches `execTag`.
- R8: `commitValid` is 1 only when the head slot has executed. `commitTag`/`commitValue` then show the head's destination tag and result. They are held unchanged while `commitReady` is 0. Slots retire strictly in issue order.
- R9: When a full buffer retires its head, `issueReady` is 1 in the next cycle.
- R10: A source marked known at issue keeps its supplied value, even when a broadcast with a matching tag arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An operation is offered at the tail |
| issueOp | input | 1 | 0 = ADD, 1 = SUB |
| issueTagA | input | TAG_W | Physical tag of source A |
| issueAValid | input | 1 | Source A value is already known |
| issueValueA | input | DATA_W | Source A value when known |
| issueTagB | input | TAG_W | Physical tag of source B |
| issueBValid | input | 1 | Source B value is already known |
| issueValueB | input | DATA_W | Source B value when known |
| issueTagD | input | TAG_W | Physical tag of the destination |
| issueReady | output | 1 | The tail slot is free |
| execEnable | input | 1 | Execution engine is available this cycle |
| execFire | output | 1 | A slot executes this cycle |
| execTag | output | TAG_W | Destination tag being broadcast |
| execValue | output | DATA_W | Result being broadcast |
| commitReady | input | 1 | Commit side accepts the head |
| commitValid | output | 1 | Head slot has executed |
| commitTag | output | TAG_W | Destination tag of the head |
| commitValue | output | DATA_W | Result of the head |

## Verification
Writing a new operation at the tail and broadcasting a result can happen at the same edge. If the new operation names the broadcast tag as an unknown source, it must take the value then, or it waits forever. The bench provokes this by issuing a consumer in the very cycle its producer executes. It judges the outcome by the consumer's later `execValue`, which also shows whether a source already marked known kept its supplied value. Retirement and execution also overlap when the engine is held off to build a backlog and then released. The bench checks that the broadcast order stays oldest-first while the held head retires independently.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } robOpE;

  // Strobes from control to datapath; indices travel on separate ports
  typedef struct packed {
    logic issueWe;
    logic execWe;
    logic commitWe;
  } robStrobeT;

endpackage

// File: rtl/rob_control.sv
module rob_control
  import rob_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             execEnable,
  input  logic             commitReady,
  input  logic [DEPTH-1:0] readyVec,
  input  logic [DEPTH-1:0] usedVec,
  input  logic [DEPTH-1:0] doneVec,
  output robStrobeT        strobe,
  output logic [IDX_W-1:0] issueIdx,
  output logic [IDX_W-1:0] execIdx,
  output logic [IDX_W-1:0] commitIdx,
  output logic             issueReady,
  output logic             commitValid
);

  logic [IDX_W-1:0] headQ;
  logic [IDX_W-1:0] tailQ;
  logic [IDX_W-1:0] scanIdx;
  logic [IDX_W-1:0] execSel;
  logic             execFound;

  // Tail slot still in use means the ring is full
  assign issueReady  = ~usedVec[tailQ];
  assign commitValid = usedVec[headQ] & doneVec[headQ];

  // Oldest-first search for a ready slot, starting at the head
  always_comb begin
    execFound = 1'b0;
    execSel   = headQ;
    scanIdx   = headQ;
    for (int k = 0; k < DEPTH; k++) begin
      scanIdx = headQ + IDX_W'(k);
      if (!execFound && readyVec[scanIdx]) begin
        execFound = 1'b1;
        execSel   = scanIdx;
      end
    end
  end

  always_comb begin
    strobe.issueWe  = issueValid & issueReady;
    strobe.execWe   = execEnable & execFound;
    strobe.commitWe = commitValid & commitReady;
  end

  assign issueIdx  = tailQ;
  assign execIdx   = execSel;
  assign commitIdx = headQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
    end else begin
      if (strobe.issueWe)  tailQ <= tailQ + 1'b1;
      if (strobe.commitWe) headQ <= headQ + 1'b1;
    end
  end

endmodule

// File: rtl/rob_datapath.sv
module rob_datapath
  import rob_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobeT         strobe,
  input  logic [IDX_W-1:0]  issueIdx,
  input  logic [IDX_W-1:0]  execIdx,
  input  logic [IDX_W-1:0]  commitIdx,
  input  robOpE             issueOp,
  input  logic [TAG_W-1:0]  issueTagA,
  input  logic              issueAValid,
  input  logic [DATA_W-1:0] issueValueA,
  input  logic [TAG_W-1:0]  issueTagB,
  input  logic              issueBValid,
  input  logic [DATA_W-1:0] issueValueB,
  input  logic [TAG_W-1:0]  issueTagD,
  output logic [DEPTH-1:0]  readyVec,
  output logic [DEPTH-1:0]  usedVec,
  output logic [DEPTH-1:0]  doneVec,
  output logic [TAG_W-1:0]  execTag,
  output logic [DATA_W-1:0] execValue,
  output logic [TAG_W-1:0]  headTag,
  output logic [DATA_W-1:0] headValue
);

  // Per-slot state
  logic [DEPTH-1:0]  usedQ;
  logic [DEPTH-1:0]  doneQ;
  logic [DEPTH-1:0]  aOkQ;
  logic [DEPTH-1:0]  bOkQ;
  robOpE             opQ   [DEPTH];
  logic [TAG_W-1:0]  tagAQ [DEPTH];
  logic [TAG_W-1:0]  tagBQ [DEPTH];
  logic [TAG_W-1:0]  tagDQ [DEPTH];
  logic [DATA_W-1:0] valAQ [DEPTH];
  logic [DATA_W-1:0] valBQ [DEPTH];
  logic [DATA_W-1:0] resQ  [DEPTH];

  logic issueAHit;
  logic issueBHit;

  assign usedVec  = usedQ;
  assign doneVec  = doneQ;
  assign readyVec = usedQ & ~doneQ & aOkQ & bOkQ;

  // Arithmetic unit on the selected slot
  always_comb begin
    execTag = tagDQ[execIdx];
    if (opQ[execIdx] == OP_SUB) execValue = valAQ[execIdx] - valBQ[execIdx];
    else                        execValue = valAQ[execIdx] + valBQ[execIdx];
  end

  assign headTag   = tagDQ[commitIdx];
  assign headValue = resQ[commitIdx];

  // Same-cycle bypass of the broadcast into an operation being written
  assign issueAHit = strobe.execWe & ~issueAValid & (issueTagA == execTag);
  assign issueBHit = strobe.execWe & ~issueBValid & (issueTagB == execTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedQ <= '0;
      doneQ <= '0;
      aOkQ  <= '0;
      bOkQ  <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (strobe.issueWe && issueIdx == IDX_W'(e)) begin
          usedQ[e] <= 1'b1;
          doneQ[e] <= 1'b0;
          opQ[e]   <= issueOp;
          tagAQ[e] <= issueTagA;
          tagBQ[e] <= issueTagB;
          tagDQ[e] <= issueTagD;
          aOkQ[e]  <= issueAValid | issueAHit;
          bOkQ[e]  <= issueBValid | issueBHit;
          valAQ[e] <= issueAHit ? execValue : issueValueA;
          valBQ[e] <= issueBHit ? execValue : issueValueB;
        end else begin
          if (strobe.commitWe && commitIdx == IDX_W'(e)) usedQ[e] <= 1'b0;
          if (strobe.execWe && execIdx == IDX_W'(e)) begin
            doneQ[e] <= 1'b1;
            resQ[e]  <= execValue;
          end
          if (strobe.execWe && usedQ[e] && !aOkQ[e] && tagAQ[e] == execTag) begin
            aOkQ[e]  <= 1'b1;
            valAQ[e] <= execValue;
          end
          if (strobe.execWe && usedQ[e] && !bOkQ[e] && tagBQ[e] == execTag) begin
            bOkQ[e]  <= 1'b1;
            valBQ[e] <= execValue;
          end
        end
      end
    end
  end

endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issueOp,
  input  logic [TAG_W-1:0]  issueTagA,
  input  logic              issueAValid,
  input  logic [DATA_W-1:0] issueValueA,
  input  logic [TAG_W-1:0]  issueTagB,
  input  logic              issueBValid,
  input  logic [DATA_W-1:0] issueValueB,
  input  logic [TAG_W-1:0]  issueTagD,
  output logic              issueReady,
  input  logic              execEnable,
  output logic              execFire,
  output logic [TAG_W-1:0]  execTag,
  output logic [DATA_W-1:0] execValue,
  input  logic              commitReady,
  output logic              commitValid,
  output logic [TAG_W-1:0]  commitTag,
  output logic [DATA_W-1:0] commitValue
);

  localparam int IDX_W = $clog2(DEPTH);

  robStrobeT        strobe;
  logic [IDX_W-1:0] issueIdx;
  logic [IDX_W-1:0] execIdx;
  logic [IDX_W-1:0] commitIdx;
  logic [DEPTH-1:0] readyVec;
  logic [DEPTH-1:0] usedVec;
  logic [DEPTH-1:0] doneVec;

  rob_control #(.DEPTH(DEPTH)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .execEnable (execEnable),
    .commitReady(commitReady),
    .readyVec   (readyVec),
    .usedVec    (usedVec),
    .doneVec    (doneVec),
    .strobe     (strobe),
    .issueIdx   (issueIdx),
    .execIdx    (execIdx),
    .commitIdx  (commitIdx),
    .issueReady (issueReady),
    .commitValid(commitValid)
  );

  rob_datapath #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .issueIdx   (issueIdx),
    .execIdx    (execIdx),
    .commitIdx  (commitIdx),
    .issueOp    (robOpE'(issueOp)),
    .issueTagA  (issueTagA),
    .issueAValid(issueAValid),
    .issueValueA(issueValueA),
    .issueTagB  (issueTagB),
    .issueBValid(issueBValid),
    .issueValueB(issueValueB),
    .issueTagD  (issueTagD),
    .readyVec   (readyVec),
    .usedVec    (usedVec),
    .doneVec    (doneVec),
    .execTag    (execTag),
    .execValue  (execValue),
    .headTag    (commitTag),
    .headValue  (commitValue)
  );

  assign execFire = strobe.execWe;

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic              issueReady,
  input logic [TAG_W-1:0]  issueTagD,
  input logic              execEnable,
  input logic              execFire,
  input logic [TAG_W-1:0]  execTag,
  input logic              commitReady,
  input logic              commitValid,
  input logic [TAG_W-1:0]  commitTag,
  input logic [DATA_W-1:0] commitValue
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // Independent program-order record of accepted destination tags
  logic [TAG_W-1:0] orderTag [DEPTH];
  logic [IDX_W-1:0] wrPtr;
  logic [IDX_W-1:0] rdPtr;
  logic [CNT_W-1:0] occ;
  logic             issueFire;
  logic             commitFire;

  assign issueFire  = issueValid & issueReady;
  assign commitFire = commitValid & commitReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (issueFire) begin
        orderTag[wrPtr] <= issueTagD;
        wrPtr           <= wrPtr + 1'b1;
      end
      if (commitFire) rdPtr <= rdPtr + 1'b1;
      occ <= occ + CNT_W'(issueFire) - CNT_W'(commitFire);
    end
  end

  // R2: ready to accept exactly while fewer than DEPTH slots are occupied
  p_full_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    issueReady == (occ != CNT_W'(DEPTH)));

  // R4: nothing executes while the engine is unavailable
  p_exec_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    !execEnable |-> !execFire);

  // R5: a slot broadcasts once, never in two consecutive cycles
  p_exec_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    execFire |=> !(execFire && execTag == $past(execTag)));

  // R8: the offered head is the oldest accepted operation
  p_commit_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (occ != '0) && (commitTag == orderTag[rdPtr]));

  // R8: an unaccepted head stays offered and unchanged
  p_commit_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    commitValid && !commitReady |=> commitValid && $stable(commitTag) && $stable(commitValue));

  // R9: retiring from a full ring reopens the tail
  p_free_after_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    commitValid && commitReady && !issueReady |=> issueReady);

endmodule

bind rob_core rob_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueReady (issueReady),
  .issueTagD  (issueTagD),
  .execEnable (execEnable),
  .execFire   (execFire),
  .execTag    (execTag),
  .commitReady(commitReady),
  .commitValid(commitValid),
  .commitTag  (commitTag),
  .commitValue(commitValue)
);

// File: tb/rob_core_bench.sv
module rob_core_bench;

  localparam int TAG_W  = 6;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              issueValid = 1'b0;
  logic              issueOp = 1'b0;
  logic [TAG_W-1:0]  issueTagA = '0;
  logic              issueAValid = 1'b0;
  logic [DATA_W-1:0] issueValueA = '0;
  logic [TAG_W-1:0]  issueTagB = '0;
  logic              issueBValid = 1'b0;
  logic [DATA_W-1:0] issueValueB = '0;
  logic [TAG_W-1:0]  issueTagD = '0;
  logic              issueReady;
  logic              execEnable = 1'b0;
  logic              execFire;
  logic [TAG_W-1:0]  execTag;
  logic [DATA_W-1:0] execValue;
  logic              commitReady = 1'b0;
  logic              commitValid;
  logic [TAG_W-1:0]  commitTag;
  logic [DATA_W-1:0] commitValue;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  rob_core #(.DEPTH(4), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_rob_core (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueOp(issueOp),
    .issueTagA(issueTagA), .issueAValid(issueAValid), .issueValueA(issueValueA),
    .issueTagB(issueTagB), .issueBValid(issueBValid), .issueValueB(issueValueB),
    .issueTagD(issueTagD), .issueReady(issueReady),
    .execEnable(execEnable), .execFire(execFire), .execTag(execTag), .execValue(execValue),
    .commitReady(commitReady), .commitValid(commitValid),
    .commitTag(commitTag), .commitValue(commitValue)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Advance to 5 ns after the next rising edge
  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic drive(input logic op, input logic [TAG_W-1:0] ta, input logic va, input logic [31:0] xa,
                       input logic [TAG_W-1:0] tb, input logic vb, input logic [31:0] xb,
                       input logic [TAG_W-1:0] td);
    issueValid = 1'b1; issueOp = op;
    issueTagA = ta; issueAValid = va; issueValueA = xa;
    issueTagB = tb; issueBValid = vb; issueValueB = xb;
    issueTagD = td;
  endtask

  task automatic expExec(input string req, input bit fire, input logic [TAG_W-1:0] tag, input logic [31:0] val);
    chk(req, "execFire", 64'(execFire), 64'(fire));
    if (fire) begin
      chk(req, "execTag", 64'(execTag), 64'(tag));
      chk(req, "execValue", 64'(execValue), 64'(val));
    end
  endtask

  task automatic expCommit(input string req, input bit vld, input logic [TAG_W-1:0] tag, input logic [31:0] val);
    chk(req, "commitValid", 64'(commitValid), 64'(vld));
    if (vld) begin
      chk(req, "commitTag", 64'(commitTag), 64'(tag));
      chk(req, "commitValue", 64'(commitValue), 64'(val));
    end
  endtask

  function automatic logic [31:0] opnd(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return 32'h1234_5678;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    rstN = 1'b1;
    settle();
    // R1: empty after reset
    chk("R1", "issueReady", 64'(issueReady), 64'd1);
    chk("R1", "commitValid", 64'(commitValid), 64'd0);
    chk("R1", "execFire", 64'(execFire), 64'd0);

    // R3/R4/R8: sweep of operand corners, both operations, one at a time
    execEnable = 1'b1;
    commitReady = 1'b1;
    for (int k = 0; k < 72; k++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] r;
      logic op;
      logic [TAG_W-1:0] td;
      a  = opnd(k / 12);
      b  = opnd((k / 2) % 6);
      op = k[0];
      r  = op ? a - b : a + b;
      td = TAG_W'(k);
      drive(op, 6'd1, 1'b1, a, 6'd2, 1'b1, b, td);
      step();
      issueValid = 1'b0;
      settle();
      expExec("R3", 1'b1, td, r);
      step();
      settle();
      expCommit("R8", 1'b1, td, r);
      expExec("R4", 1'b0, '0, '0);
      step();
    end

    // R7/R10: consumer issued while its producer broadcasts (head now 0)
    drive(1'b0, 6'd1, 1'b1, 32'd7, 6'd2, 1'b1, 32'd8, 6'd40);
    step();
    settle();
    expExec("R4", 1'b1, 6'd40, 32'd15);
    drive(1'b0, 6'd40, 1'b0, 32'd0, 6'd40, 1'b1, 32'd3, 6'd41);
    step();
    issueValid = 1'b0;
    settle();
    expCommit("R8", 1'b1, 6'd40, 32'd15);
    expExec("R7", 1'b1, 6'd41, 32'd18);   // 15 captured + 3 kept (R10)
    step();
    settle();
    expCommit("R10", 1'b1, 6'd41, 32'd18);
    step();
    settle();
    expCommit("R8", 1'b0, '0, '0);

    // R5/R2/R8/R9: backlog with wrapped head (head now 2)
    execEnable = 1'b0;
    commitReady = 1'b0;
    drive(1'b0, 6'd1, 1'b1, 32'd1, 6'd2, 1'b1, 32'd2, 6'd50);
    step();
    drive(1'b1, 6'd1, 1'b1, 32'd10, 6'd2, 1'b1, 32'd3, 6'd51);
    settle();
    chk("R2", "issueReady", 64'(issueReady), 64'd1);
    step();
    drive(1'b0, 6'd1, 1'b1, 32'd100, 6'd2, 1'b1, 32'd23, 6'd52);
    step();
    drive(1'b1, 6'd1, 1'b1, 32'd0, 6'd2, 1'b1, 32'd1, 6'd53);
    step();
    drive(1'b0, 6'd1, 1'b1, 32'd5, 6'd2, 1'b1, 32'd5, 6'd60);
    settle();
    chk("R2", "issueReady full", 64'(issueReady), 64'd0);
    expExec("R4", 1'b0, '0, '0);
    expCommit("R8", 1'b0, '0, '0);
    step();
    issueValid = 1'b0;
    execEnable = 1'b1;
    settle();
    chk("R2", "issueReady still full", 64'(issueReady), 64'd0);
    expExec("R5", 1'b1, 6'd50, 32'd3);
    step();
    settle();
    expExec("R5", 1'b1, 6'd51, 32'd7);
    expCommit("R8", 1'b1, 6'd50, 32'd3);
    step();
    settle();
    expExec("R5", 1'b1, 6'd52, 32'd123);
    expCommit("R8", 1'b1, 6'd50, 32'd3);
    step();
    settle();
    expExec("R5", 1'b1, 6'd53, 32'hFFFF_FFFF);
    expCommit("R8", 1'b1, 6'd50, 32'd3);
    step();
    settle();
    expExec("R5", 1'b0, '0, '0);
    expCommit("R8", 1'b1, 6'd50, 32'd3);
    commitReady = 1'b1;
    settle();
    chk("R9", "issueReady before retire", 64'(issueReady), 64'd0);
    step();
    settle();
    chk("R9", "issueReady after retire", 64'(issueReady), 64'd1);
    expCommit("R8", 1'b1, 6'd51, 32'd7);
    step();
    settle();
    expCommit("R8", 1'b1, 6'd52, 32'd123);
    step();
    settle();
    expCommit("R8", 1'b1, 6'd53, 32'hFFFF_FFFF);
    step();
    settle();
    expCommit("R2", 1'b0, '0, '0);   // the dropped operation never appears

    // R6: dependency chain waiting inside the buffer (head now 2)
    execEnable = 1'b0;
    drive(1'b0, 6'h01, 1'b1, 32'd10, 6'h02, 1'b1, 32'd20, 6'h03);
    step();
    drive(1'b1, 6'h03, 1'b0, 32'd0, 6'h01, 1'b1, 32'd10, 6'h13);
    step();
    drive(1'b0, 6'h02, 1'b1, 32'd20, 6'h13, 1'b0, 32'd0, 6'h04);
    step();
    drive(1'b1, 6'h13, 1'b0, 32'd0, 6'h04, 1'b0, 32'd0, 6'h05);
    step();
    issueValid = 1'b0;
    settle();
    expExec("R4", 1'b0, '0, '0);
    expCommit("R8", 1'b0, '0, '0);
    execEnable = 1'b1;
    settle();
    expExec("R4", 1'b1, 6'h03, 32'd30);
    step();
    settle();
    expExec("R6", 1'b1, 6'h13, 32'd20);
    expCommit("R8", 1'b1, 6'h03, 32'd30);
    step();
    settle();
    expExec("R6", 1'b1, 6'h04, 32'd40);
    expCommit("R8", 1'b1, 6'h13, 32'd20);
    step();
    settle();
    expExec("R6", 1'b1, 6'h05, 32'hFFFF_FFEC);
    expCommit("R8", 1'b1, 6'h04, 32'd40);
    step();
    settle();
    expExec("R6", 1'b0, '0, '0);
    expCommit("R8", 1'b1, 6'h05, 32'hFFFF_FFEC);
    step();
    settle();
    expCommit("R8", 1'b0, '0, '0);
    chk("R9", "issueReady empty", 64'(issueReady), 64'd1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule